// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Decay Control

This block drives the four gates of one full bridge: a high-side and a low-side switch on each of two legs, A and B. A direction bit chooses which diagonal pair conducts during the chopper on interval. A chopper request marks the off interval. During that interval a decay select picks the switch pattern. In fast decay, all conducting devices open and, after the dead time, only one low-side device is driven. This is quasi-synchronous rectification, and it keeps the winding current from reversing. In slow decay, only the low-side device opens and, after the dead time, the second high-side device closes so the current recirculates through the upper half of the bridge.

Every transition goes through a dead-time window, counted in clock cycles. Any gate that must turn off does so at once. No gate may turn on until the window has run its full length. A bridge-enable input and a fault input both turn every gate off in the same cycle and hold them off. When the block is released, it restarts from the all-off state with a fresh dead time.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: With the chopper request low and the bridge released, the settled gate vector {gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b} is 1001 when dir is 1 and 0110 when dir is 0.
- R2: In fast decay (decay_slow = 0) with quasi-synchronous rectification, the settled off-interval vector is 0100 for dir 1 and 0001 for dir 0.
- R3: When the off interval starts in fast decay, both conducting gates open on the first clock edge. The vector stays 0000 for DEAD_CYC cycles before the low-side device closes.
- R4: When the off interval starts in slow decay, only the conducting low-side gate opens on the first edge, and the high-side gate stays on. After DEAD_CYC cycles the other high-side gate closes, which gives 1010.
- R5: No gate turns on earlier than DEAD_CYC clock cycles after the most recent gate turn-off. This includes the return from the off interval to the on pattern.
- R6: Neither leg ever has its high-side and low-side gates on together.
- R7: When bridge_en is low, all four gates are off in that same cycle. After bridge_en rises, no gate turns on for DEAD_CYC cycles.
- R8: When fault is high, all four gates are off in that same cycle and stay off until fault clears. After fault clears, the block restarts with a full dead time.
- R9: A change of dir during the on interval first drives all four gates off for DEAD_CYC cycles. Only then does the new diagonal close.
- R10: During reset all gates are off. After reset is released, the first gate turn-on comes exactly DEAD_CYC cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bridge_en | input | 1 | High lets the bridge switch. Low forces all gates off |
| fault | input | 1 | High forces all gates off until it clears |
| dir | input | 1 | 1: leg A high / leg B low. 0: the reverse |
| chop_off | input | 1 | High requests the chopper off interval |
| decay_slow | input | 1 | 1: slow decay. 0: fast decay |
| gate_hi_a | output | 1 | Leg A high-side gate command |
| gate_lo_a | output | 1 | Leg A low-side gate command |
| gate_hi_b | output | 1 | Leg B high-side gate command |
| gate_lo_b | output | 1 | Leg B low-side gate command |

## Verification
Directed sequences start from a settled on interval and enter the off interval in each decay mode. Each sequence samples the first edge, the last cycle of the dead window and the first cycle after it. This shows whether one gate or two open first, and whether the off pattern closes early or late. A direction flip during the on interval is checked separately from the decay transitions, because it must pass through all-off. The enable and fault drops are checked in the same cycle as the drop, and again after release, which separates a purely combinational mask from a proper restart with dead time. A long random mix of direction, chopper, decay, enable and fault patterns then checks every settled vector against the expected table. All the while, a monitor watches for leg shoot-through and for turn-ons that come too soon.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
   localparam int unsigned NGATE = 4;
   typedef logic [NGATE-1:0] gate_vec_t;
   // bit positions inside gate_vec_t
   localparam int unsigned HI_A = 3;
   localparam int unsigned LO_A = 2;
   localparam int unsigned HI_B = 1;
   localparam int unsigned LO_B = 0;
   typedef enum logic [1:0] {SEG_DRIVE, SEG_SLOW, SEG_FAST} seg_e;
endpackage

// File: rtl/hbg_pattern.sv
module hbg_pattern
   import hbg_pkg::*;
#(
   parameter bit QUASI_SYNC = 1'b1
) (
   input  logic      dir,
   input  logic      chop_off,
   input  logic      decay_slow,
   input  logic      inhibit,
   output gate_vec_t tgt
);
   gate_vec_t drive_v, slow_v, fast_v;
   seg_e      seg;

   always_comb begin
      drive_v = '0;
      if (dir) begin
         drive_v[HI_A] = 1'b1;
         drive_v[LO_B] = 1'b1;
      end else begin
         drive_v[HI_B] = 1'b1;
         drive_v[LO_A] = 1'b1;
      end
   end

   // slow decay: both upper devices carry the recirculating current
   always_comb begin
      slow_v       = '0;
      slow_v[HI_A] = 1'b1;
      slow_v[HI_B] = 1'b1;
   end

   generate
      if (QUASI_SYNC) begin : g_quasi
         // only the low device beside the conducting diode is driven
         always_comb begin
            fast_v = '0;
            if (dir) fast_v[LO_A] = 1'b1;
            else     fast_v[LO_B] = 1'b1;
         end
      end else begin : g_full_sync
         // both diode-parallel devices are driven (reverse diagonal)
         always_comb begin
            fast_v = '0;
            if (dir) begin
               fast_v[LO_A] = 1'b1;
               fast_v[HI_B] = 1'b1;
            end else begin
               fast_v[LO_B] = 1'b1;
               fast_v[HI_A] = 1'b1;
            end
         end
      end
   endgenerate

   always_comb begin
      if (!chop_off)       seg = SEG_DRIVE;
      else if (decay_slow) seg = SEG_SLOW;
      else                 seg = SEG_FAST;
   end

   always_comb begin
      if (inhibit) tgt = '0;
      else begin
         case (seg)
            SEG_DRIVE: tgt = drive_v;
            SEG_SLOW:  tgt = slow_v;
            default:   tgt = fast_v;
         endcase
      end
   end
endmodule

// File: rtl/hbg_dead_timer.sv
module hbg_dead_timer #(
   parameter int unsigned DEAD_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic expired
);
   localparam int unsigned CNT_W = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DEAD_CYC - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= RELOAD;
      else if (restart)      cnt <= RELOAD;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);
endmodule

// File: rtl/hbg_gate_seq.sv
module hbg_gate_seq
   import hbg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  gate_vec_t tgt,
   input  logic      expired,
   input  logic      inhibit,
   output logic      restart,
   output gate_vec_t gates
);
   gate_vec_t held, drop_v, add_v;

   assign drop_v  = held & ~tgt;
   assign add_v   = tgt & ~held;
   // any opening, or a held-off bridge, re-arms the dead window
   assign restart = inhibit | (|drop_v);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      held <= '0;
      else if (|drop_v)                held <= held & tgt;
      else if ((|add_v) && expired)    held <= tgt;
   end

   assign gates = inhibit ? '0 : held;
endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
   import hbg_pkg::*;
#(
   parameter int unsigned DEAD_CYC   = 100,
   parameter bit          QUASI_SYNC = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bridge_en,
   input  logic fault,
   input  logic dir,
   input  logic chop_off,
   input  logic decay_slow,
   output logic gate_hi_a,
   output logic gate_lo_a,
   output logic gate_hi_b,
   output logic gate_lo_b
);
   generate
      if (DEAD_CYC < 1) begin : g_bad_dead
         $error("DEAD_CYC must be at least 1");
      end
   endgenerate

   logic      inhibit, restart, expired;
   gate_vec_t tgt, gates;

   assign inhibit = ~bridge_en | fault;

   hbg_pattern #(.QUASI_SYNC(QUASI_SYNC)) u_pat (
      .dir        (dir),
      .chop_off   (chop_off),
      .decay_slow (decay_slow),
      .inhibit    (inhibit),
      .tgt        (tgt)
   );

   hbg_dead_timer #(.DEAD_CYC(DEAD_CYC)) u_dt (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .expired (expired)
   );

   hbg_gate_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .tgt     (tgt),
      .expired (expired),
      .inhibit (inhibit),
      .restart (restart),
      .gates   (gates)
   );

   assign gate_hi_a = gates[HI_A];
   assign gate_lo_a = gates[LO_A];
   assign gate_hi_b = gates[HI_B];
   assign gate_lo_b = gates[LO_B];
endmodule

// File: rtl/hbridge_gate_ctrl_chk.sv
module hbridge_gate_ctrl_chk #(
   parameter int unsigned DEAD_CYC = 100
) (
   input logic clk,
   input logic rst_n,
   input logic bridge_en,
   input logic fault,
   input logic gate_hi_a,
   input logic gate_lo_a,
   input logic gate_hi_b,
   input logic gate_lo_b
);
   localparam int unsigned QW = $clog2(DEAD_CYC + 1);
   localparam logic [QW-1:0] QMAX = QW'(DEAD_CYC);

   logic [3:0]    cur, prev;
   logic [QW-1:0] quiet;
   logic          fell, rose;

   assign cur  = {gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b};
   assign fell = |(prev & ~cur);
   assign rose = |(~prev & cur);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev  <= '0;
         quiet <= QMAX;
      end else begin
         prev <= cur;
         if (fell)              quiet <= QW'(1);
         else if (quiet < QMAX) quiet <= quiet + 1'b1;
      end
   end

   // R6
   leg_a_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi_a && gate_lo_a));
   // R6
   leg_b_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_hi_b && gate_lo_b));
   // R7
   enable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bridge_en |-> (cur == 4'b0000));
   // R8
   fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> (cur == 4'b0000));
   // R5
   dead_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rose |-> ((quiet >= QMAX) && !fell));
endmodule

bind hbridge_gate_ctrl hbridge_gate_ctrl_chk #(.DEAD_CYC(DEAD_CYC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bridge_en (bridge_en),
   .fault     (fault),
   .gate_hi_a (gate_hi_a),
   .gate_lo_a (gate_lo_a),
   .gate_hi_b (gate_hi_b),
   .gate_lo_b (gate_lo_b)
);

// File: tb/sim_hbridge_gate_ctrl.sv
`timescale 1ns/1ps
module sim_hbridge_gate_ctrl;
   localparam int DT        = 100;
   localparam int CYC_LIMIT = 150000;

   logic clk = 1'b0;
   logic rst_n, bridge_en, fault, dir, chop_off, decay_slow;
   logic gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   hbridge_gate_ctrl #(.DEAD_CYC(DT), .QUASI_SYNC(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .bridge_en(bridge_en), .fault(fault),
      .dir(dir), .chop_off(chop_off), .decay_slow(decay_slow),
      .gate_hi_a(gate_hi_a), .gate_lo_a(gate_lo_a),
      .gate_hi_b(gate_hi_b), .gate_lo_b(gate_lo_b)
   );

   function automatic logic [3:0] obs();
      return {gate_hi_a, gate_lo_a, gate_hi_b, gate_lo_b};
   endfunction

   // settled vector from the requirements (R1, R2, R4)
   function automatic logic [3:0] exp_gates(bit d, bit ch, bit sl, bit en, bit flt);
      if (!en || flt) return 4'b0000;
      if (!ch)        return d ? 4'b1001 : 4'b0110;
      if (sl)         return 4'b1010;
      return d ? 4'b0100 : 4'b0001;
   endfunction

   task automatic check(input logic [3:0] exp, input string req);
      vectors++;
      if (obs() !== exp) begin
         miscompares++;
         $display("FAIL %s: gates=%b expected=%b at %0t", req, obs(), exp, $time);
      end
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // after a change driven at a negedge: value at first edge, through the
   // dead window, then the value once it has elapsed
   task automatic dead_seq(input logic [3:0] first, input logic [3:0] final_v, input string req);
      wait_neg(1);
      check(first, req);
      wait_neg(DT - 1);
      check(first, req);
      wait_neg(1);
      check(final_v, req);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   // monitor: shoot-through, dead gap and masking (R5, R6, R7, R8)
   logic [3:0] mon_prev;
   int         since;
   always @(posedge clk) begin
      #2;
      if (!rst_n) begin
         mon_prev = 4'b0000;
         since    = DT;
      end else begin
         logic [3:0] cur;
         cur = obs();
         vectors++;
         if ((cur[3] && cur[2]) || (cur[1] && cur[0])) begin
            miscompares++;
            $display("FAIL R6: gates=%b expected no leg with both on", cur);
         end
         if ((|(~mon_prev & cur)) && since < DT) begin
            miscompares++;
            $display("FAIL R5: turn-on after %0d cycles, expected >= %0d", since, DT);
         end
         if ((!bridge_en || fault) && cur != 4'b0000) begin
            miscompares++;
            $display("FAIL R7/R8: gates=%b expected=0000 while held off", cur);
         end
         if (|(mon_prev & ~cur)) since = 1;
         else if (since < DT) since++;
         mon_prev = cur;
      end
   end

   initial begin
      #(CYC_LIMIT * 10);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: run hung, actual=running expected=finished");
         summary();
      end
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      rst_n = 1'b0; bridge_en = 1'b1; fault = 1'b0;
      dir = 1'b1; chop_off = 1'b0; decay_slow = 1'b0;
      wait_neg(3);
      check(4'b0000, "R10 reset");
      rst_n = 1'b1;
      // R10: first turn-on exactly DT edges after release
      wait_neg(DT - 1);
      check(4'b0000, "R10");
      wait_neg(1);
      check(4'b1001, "R1 R10");

      // R3 / R2: fast decay entry, dir 1
      chop_off = 1'b1;
      dead_seq(4'b0000, 4'b0100, "R3 R2");
      // R5: back to the on interval
      chop_off = 1'b0;
      dead_seq(4'b0000, 4'b1001, "R5");
      // R4: slow decay
      decay_slow = 1'b1; chop_off = 1'b1;
      dead_seq(4'b1000, 4'b1010, "R4");
      chop_off = 1'b0;
      dead_seq(4'b1000, 4'b1001, "R5 slow exit");
      // R9: direction flip during on interval
      dir = 1'b0;
      dead_seq(4'b0000, 4'b0110, "R9 R1");
      // R2: fast decay, dir 0
      decay_slow = 1'b0; chop_off = 1'b1;
      dead_seq(4'b0000, 4'b0001, "R2");

      // R7: enable drop is immediate, restart waits
      bridge_en = 1'b0;
      #1 check(4'b0000, "R7 same cycle");
      wait_neg(3);
      check(4'b0000, "R7 held");
      bridge_en = 1'b1;
      wait_neg(DT - 1);
      check(4'b0000, "R7 restart");
      wait_neg(1);
      check(4'b0001, "R7 restart");

      // R8: fault
      chop_off = 1'b0;
      wait_neg(DT + 2);
      check(4'b0110, "R1 settle");
      fault = 1'b1;
      #1 check(4'b0000, "R8 same cycle");
      wait_neg(5);
      check(4'b0000, "R8 held");
      fault = 1'b0;
      wait_neg(DT - 1);
      check(4'b0000, "R8 restart");
      wait_neg(1);
      check(4'b0110, "R8 restart");

      // random mix, settled values checked against the table
      for (int it = 0; it < 300; it++) begin
         logic [31:0] r;
         r = $urandom();
         dir        = r[0];
         chop_off   = r[1];
         decay_slow = r[2];
         bridge_en  = (r[5:3] != 3'd0);
         fault      = (r[9:6] == 4'd0);
         wait_neg(DT + 2);
         check(exp_gates(dir, chop_off, decay_slow, bridge_en, fault), "R1 R2 R4 R7 R8 random");
      end
      summary();
   end
endmodule